// File: doc/BRIEF.md
# ECC Strength and Erased-Page Threshold Control Register

This block is one 32-bit control register inside a flash memory controller's configuration space. It holds two things. The first is the error-correction strength that the controller's ECC engine applies to each sector. The second is the zero-count limit that the engine uses to decide that a page was erased and is not corrupted. Software writes the register through a plain write/read port. The block decodes the byte address and acts only on the word at offset 0x1B0. An aligned word access at any other address does nothing to the register.

The strength field accepts only the values that the engine supports. A write that carries any other strength is dropped, and the field keeps the value it had before. The threshold field in the same write still loads. From the stored strength the block drives two outputs for downstream logic:

- the ECC sector size;
- the number of check bytes stored per sector.

A lower strength needs fewer check bytes. Register updates are registered and show on the outputs one clock after the write. The read path is combinational from the read address.

Top module: `ecc_cfg_reg`

## Requirements
- R1: After reset the strength field is 8, the threshold field is 0, a read of offset 0x1B0 returns 0x00000008, the sector size is 512 and the check-byte count is 13.
- R2: A write to offset 0x1B0 whose bits 7:0 hold 4, 8 or 16 stores that strength, and the sector size becomes 512.
- R3: A write to offset 0x1B0 whose bits 7:0 hold 24 stores that strength, and the sector size becomes 1024.
- R4: A write to offset 0x1B0 whose bits 7:0 hold any value other than 4, 8, 16 or 24 leaves the stored strength unchanged.
- R5: Every write to offset 0x1B0 loads bits 31:16 into the threshold field with no filtering, whether or not the strength in the same write is accepted.
- R6: Bits 15:8 of the register read as zero, and data written to them is discarded.
- R7: The check-byte count equals ceil(strength*13/8) for 512-byte sectors and ceil(strength*14/8) for 1024-byte sectors. The four possible counts are 4→7, 8→13, 16→26 and 24→42.
- R8: A write to any byte address other than 0x1B0, unaligned addresses included, changes nothing. A read of any other address returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one word per cycle |
| wr_addr | input | 12 | Byte address of the write |
| wr_data | input | 32 | Write data word |
| rd_addr | input | 12 | Byte address of the read |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| corr_strength | output | 8 | Accepted correction strength |
| erase_thresh | output | 16 | Erased-page zero-count threshold |
| sector_bytes | output | 11 | ECC sector size in bytes (512 or 1024) |
| check_bytes | output | 8 | Check bytes per ECC sector |

## Verification
The hardest case to provoke is a single write that carries a rejected strength together with a new threshold. In that write one field must load while the other keeps its old value. The directed stimulus first moves the strength away from its reset value to 24. It then sends illegal codes (12, 0 and 255), each paired with a new threshold. This shows that the held value is the previously accepted one and not the reset value. Unaligned and neighbouring addresses carrying legal data are also written, to show that the decode rejects them.

// File: rtl/ecc_cfg_pkg.sv
package ecc_cfg_pkg;
  typedef enum logic {SECT_512 = 1'b0, SECT_1K = 1'b1} sect_e;

  function automatic logic strength_ok(input logic [7:0] s);
    return (s == 8'd4) || (s == 8'd8) || (s == 8'd16) || (s == 8'd24);
  endfunction

  function automatic sect_e sect_of(input logic [7:0] s);
    return (s == 8'd24) ? SECT_1K : SECT_512;
  endfunction

  // log2 of the sector size in bytes; symbol width in bits is this plus 4
  function automatic int unsigned sect_log2(input sect_e k);
    return (k == SECT_1K) ? 32'd10 : 32'd9;
  endfunction
endpackage

// File: rtl/ecc_cfg_decode.sv
module ecc_cfg_decode #(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 12'h1B0
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              wr_hit,
  output logic              rd_hit
);
  assign wr_hit = wr_en && (wr_addr == REG_OFFSET);
  assign rd_hit = (rd_addr == REG_OFFSET);
endmodule

// File: rtl/ecc_cfg_field.sv
module ecc_cfg_field #(
  parameter int W = 16,
  parameter logic [W-1:0] RST_VAL = '0,
  parameter bit FILTER = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  import ecc_cfg_pkg::*;
  logic accept;

  generate
    if (FILTER) begin : g_filter
      assign accept = we && strength_ok(8'(wdata));
    end else begin : g_plain
      assign accept = we;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= RST_VAL;
    else if (accept) q <= wdata;
  end
endmodule

// File: rtl/ecc_cfg_derive.sv
module ecc_cfg_derive #(
  parameter int STR_W  = 8,
  parameter int SECT_W = 11,
  parameter int CB_W   = 8
) (
  input  logic [STR_W-1:0]  strength,
  output logic [SECT_W-1:0] sector_bytes,
  output logic [CB_W-1:0]   check_bytes
);
  import ecc_cfg_pkg::*;
  sect_e       kind;
  int unsigned lg;
  int unsigned bits;

  always_comb begin
    kind         = sect_of(8'(strength));
    lg           = sect_log2(kind);
    bits         = 32'(strength) * (lg + 32'd4);
    sector_bytes = SECT_W'(32'd1 << lg);
    check_bytes  = CB_W'((bits + 32'd7) >> 3);
  end
endmodule

// File: rtl/ecc_cfg_reg.sv
module ecc_cfg_reg #(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 12'h1B0,
  parameter int DATA_W = 32,
  parameter int STR_W  = 8,
  parameter int THR_W  = 16,
  parameter int THR_LSB = 16,
  parameter logic [STR_W-1:0] STR_RST = 8'd8,
  parameter int SECT_W = 11,
  parameter int CB_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [STR_W-1:0]  corr_strength,
  output logic [THR_W-1:0]  erase_thresh,
  output logic [SECT_W-1:0] sector_bytes,
  output logic [CB_W-1:0]   check_bytes
);
  localparam int RSV_W = THR_LSB - STR_W;

  logic wr_hit, rd_hit;
  logic unused_rsvd;

  assign unused_rsvd = ^wr_data[THR_LSB-1:STR_W];

  ecc_cfg_decode #(.ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)) u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr), .rd_addr(rd_addr),
    .wr_hit(wr_hit), .rd_hit(rd_hit)
  );

  ecc_cfg_field #(.W(STR_W), .RST_VAL(STR_RST), .FILTER(1'b1)) u_str (
    .clk(clk), .rst_n(rst_n), .we(wr_hit),
    .wdata(wr_data[STR_W-1:0]), .q(corr_strength)
  );

  ecc_cfg_field #(.W(THR_W), .RST_VAL('0), .FILTER(1'b0)) u_thr (
    .clk(clk), .rst_n(rst_n), .we(wr_hit),
    .wdata(wr_data[THR_LSB +: THR_W]), .q(erase_thresh)
  );

  ecc_cfg_derive #(.STR_W(STR_W), .SECT_W(SECT_W), .CB_W(CB_W)) u_drv (
    .strength(corr_strength), .sector_bytes(sector_bytes),
    .check_bytes(check_bytes)
  );

  assign rd_data = rd_hit ? {erase_thresh, {RSV_W{1'b0}}, corr_strength}
                          : '0;
endmodule

// File: rtl/ecc_cfg_reg_chk.sv
module ecc_cfg_reg_chk #(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 12'h1B0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [31:0]       wr_data,
  input logic [7:0]        corr_strength,
  input logic [15:0]       erase_thresh,
  input logic [10:0]       sector_bytes,
  input logic [7:0]        check_bytes
);
  logic hit, legal;
  assign hit   = wr_en && (wr_addr == REG_OFFSET);
  assign legal = (wr_data[7:0] == 8'd4) || (wr_data[7:0] == 8'd8) ||
                 (wr_data[7:0] == 8'd16) || (wr_data[7:0] == 8'd24);

  AST_LEGAL_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    hit && legal |=> corr_strength == $past(wr_data[7:0])); // R2
  AST_BIG_SECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    corr_strength == 8'd24 |-> sector_bytes == 11'd1024); // R3
  AST_ILLEGAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    hit && !legal |=> $stable(corr_strength)); // R4
  AST_THRESH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> erase_thresh == $past(wr_data[31:16])); // R5
  AST_BIG_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
    sector_bytes == 11'd1024 |-> check_bytes == 8'd42); // R7
  AST_MISS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(corr_strength) && $stable(erase_thresh)); // R8
endmodule

bind ecc_cfg_reg ecc_cfg_reg_chk #(.ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .corr_strength(corr_strength),
  .erase_thresh(erase_thresh), .sector_bytes(sector_bytes),
  .check_bytes(check_bytes)
);

// File: tb/ecc_cfg_reg_tb.sv
module ecc_cfg_reg_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] OFS = 12'h1B0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [11:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [11:0] rd_addr = OFS;
  logic [31:0] rd_data;
  logic [7:0]  corr_strength;
  logic [15:0] erase_thresh;
  logic [10:0] sector_bytes;
  logic [7:0]  check_bytes;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecc_cfg_reg u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .corr_strength(corr_strength), .erase_thresh(erase_thresh),
    .sector_bytes(sector_bytes), .check_bytes(check_bytes)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // drive at negedge, register updates at next posedge, sample at following negedge
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
  endtask

  task automatic expect_state(input string tag, input logic [7:0] s,
                              input logic [15:0] t, input logic [10:0] sb,
                              input logic [7:0] cb);
    rd_addr = OFS; #1;
    chk({tag, " strength"}, 32'(corr_strength), 32'(s));
    chk({tag, " thresh"},   32'(erase_thresh), 32'(t));
    chk({tag, " sector"},   32'(sector_bytes), 32'(sb));
    chk({tag, " checkbytes"}, 32'(check_bytes), 32'(cb));
    chk({tag, " readback"}, rd_data, {t, 8'h00, s});
  endtask

  task automatic t_reset();
    expect_state("R1 reset", 8'd8, 16'h0000, 11'd512, 8'd13);
  endtask

  task automatic t_small_strengths();
    wr(OFS, 32'h1234_0004);
    expect_state("R2 R7 s4", 8'd4, 16'h1234, 11'd512, 8'd7);
    wr(OFS, 32'h0000_0010);
    expect_state("R2 R7 s16", 8'd16, 16'h0000, 11'd512, 8'd26);
    wr(OFS, 32'h0001_0008);
    expect_state("R2 R7 s8", 8'd8, 16'h0001, 11'd512, 8'd13);
  endtask

  task automatic t_large();
    wr(OFS, 32'h00AB_0018);
    expect_state("R3 R7 s24", 8'd24, 16'h00AB, 11'd1024, 8'd42);
  endtask

  task automatic t_illegal();
    wr(OFS, 32'hBEEF_000C);
    expect_state("R4 R5 illegal12", 8'd24, 16'hBEEF, 11'd1024, 8'd42);
    wr(OFS, 32'hFFFF_0000);
    expect_state("R4 R5 illegal0", 8'd24, 16'hFFFF, 11'd1024, 8'd42);
    wr(OFS, 32'h0002_00FF);
    expect_state("R4 R5 illegal255", 8'd24, 16'h0002, 11'd1024, 8'd42);
  endtask

  task automatic t_reserved();
    wr(OFS, 32'h5555_FF08);
    expect_state("R6 rsvd", 8'd8, 16'h5555, 11'd512, 8'd13);
    chk("R6 rsvd bits", 32'(rd_data[15:8]), 32'h0);
  endtask

  task automatic t_addr_miss();
    wr(12'h1B4, 32'hFFFF_0004);
    wr(12'h1B1, 32'h1111_0010);
    wr(12'h1AC, 32'h2222_0018);
    expect_state("R8 miss", 8'd8, 16'h5555, 11'd512, 8'd13);
    rd_addr = 12'h1AC; #1;
    chk("R8 read miss", rd_data, 32'h0);
    rd_addr = 12'h1B2; #1;
    chk("R8 read unaligned", rd_data, 32'h0);
    rd_addr = OFS;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_small_strengths();
    t_large();
    t_illegal();
    t_reserved();
    t_addr_miss();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule